// File: doc/BRIEF.md
# Five-Slot Dispatch Group Hazard Checker

This block tracks how full the current dispatch group is and judges each candidate instruction against it. A group holds up to five issue positions, and only the last one may take a branch. A scheduler presents one candidate at a time: its execution-unit class and a handful of flags (first-only, single, cracked, sets-counter, branch-through-counter, load, store). The block answers in the same cycle with a hazard code. The code says the candidate may issue, that it must wait for a later group, or that no-ops are needed to split the group first.

When the scheduler commits a candidate, it pulses `emit`. The block then updates the slot count and records whether the group has written the counter register or holds stores. A pulse on `advance` uses up one empty position. The group closes when five positions are used. An address comparator outside this block supplies `addr_overlap`, which says whether the candidate load's address overlaps a store held in the current group. The strobes are plain single-cycle pulses with no handshake. The hazard answer is purely combinational, so there is no back-pressure path.

Top module: `dispatch_hazard_top`

## Requirements
- R1: After reset the slot count is 0, the overrun flag is 0, and a plain fixed-point candidate gets the hazard code 0 (none). The hazard codes are 0 for none, 1 for stall and 2 for needs-no-op.
- R2: A candidate of unit class 7 (pseudo) always gets code 0, and emitting it changes neither the slot count nor any group flag.
- R3: A candidate flagged first-only or single gets code 1 whenever the slot count is nonzero.
- R4: A cracked candidate gets code 1 when the slot count is greater than 2.
- R5: The unit classes are encoded 0 fixed-point, 1 load/store, 2 float, 3 vector ALU, 4 vector permute, 5 condition-register and 6 branch. Classes 0 to 4 get code 1 at slot count 4. Class 5 gets code 1 at slot count 2 or more. Class 6 has no position limit.
- R6: If no stall rule applies, the candidate gets code 2 in either of two cases. The first is a branch-through-counter candidate while the group's counter-set flag is true. The second is a load with `addr_overlap` high while the group holds at least one store. Every stall rule takes priority over both of these.
- R7: On emit, the count is computed in steps. A branch-class or single candidate first forces the count to 4. One position is then added, and one more if the candidate is cracked. A result of exactly 5 closes the group, clearing the count, the counter-set flag and the stores. A result above 5 leaves the count at 6 (overfull).
- R8: An emit with the sets-counter flag raises the group's counter-set flag. An emit with the store flag records a store, up to four per group.
- R9: An advance adds one position, and reaching 5 closes the group. When emit and advance arrive in the same cycle, the emit is applied first and the advance is applied to its result.
- R10: An advance that meets a slot count of 5 or more (after any same-cycle emit) sets a sticky overrun flag and closes the group. Only reset clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_unit | input | 3 | Candidate unit class (0 to 7, see R5 and R2) |
| cand_first | input | 1 | Candidate must lead its group |
| cand_single | input | 1 | Candidate occupies the group alone |
| cand_cracked | input | 1 | Candidate splits into two operations |
| cand_sets_ctr | input | 1 | Candidate writes the counter register |
| cand_ctr_branch | input | 1 | Candidate branches through the counter register |
| cand_load | input | 1 | Candidate reads memory |
| cand_store | input | 1 | Candidate writes memory |
| addr_overlap | input | 1 | Candidate load overlaps a store of the group (from an outside comparator) |
| emit | input | 1 | Commit the presented candidate to the group |
| advance | input | 1 | Consume one empty position |
| hazard | output | 2 | Hazard code: 0 none, 1 stall, 2 needs-no-op |
| slot_cnt | output | 3 | Positions used in the current group (6 means overfull) |
| overrun_err | output | 1 | Sticky flag: an advance arrived with the group at 5 or more |

## Verification
The hazard answer is swept over every combination of unit class and the six candidate flags. The sweep is repeated at every reachable slot count and with each setting of the counter-set and store-present state. This separates position limits by class, the cracked and first-only limits, and the priority of stall over no-op. A second sweep emits branch, single, cracked, condition-register and pseudo candidates from each slot count. It reads back the resulting count and counter flag, which distinguishes forced closure, the double position of a cracked candidate, and overfull. Directed sequences cover clearing of stores when a group closes, emit and advance in the same cycle, and the sticky overrun flag.

// File: rtl/dhz_pkg.sv
package dhz_pkg;

  typedef enum logic [2:0] {
    U_FIX    = 3'd0,
    U_LDST   = 3'd1,
    U_FLT    = 3'd2,
    U_VALU   = 3'd3,
    U_VPERM  = 3'd4,
    U_COND   = 3'd5,
    U_BRANCH = 3'd6,
    U_PSEUDO = 3'd7
  } unit_e;

  typedef enum logic [1:0] {
    HZ_NONE  = 2'd0,
    HZ_STALL = 2'd1,
    HZ_NOOP  = 2'd2
  } hazard_e;

  typedef struct packed {
    unit_e unit;
    logic  first;
    logic  single;
    logic  cracked;
    logic  sets_ctr;
    logic  ctr_branch;
    logic  load;
    logic  store;
  } cand_t;

endpackage

// File: rtl/dhz_rules.sv
module dhz_rules
  import dhz_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int CR_SLOTS    = 2,
  parameter int CNT_W       = 3
) (
  input  cand_t            cand,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ctr_set,
  input  logic             stores_any,
  input  logic             overlap,
  output hazard_e          hz
);
  localparam int LAST_SLOT   = GROUP_SLOTS - 1;
  localparam int CRACK_LIMIT = GROUP_SLOTS - 3;

  logic stall_lead, stall_crack, stall_pos, noop_ctr, noop_mem;

  always_comb begin
    stall_lead  = (cand.first || cand.single) && (cnt != '0);
    stall_crack = cand.cracked && (cnt > CNT_W'(CRACK_LIMIT));
    unique case (cand.unit)
      U_FIX, U_LDST, U_FLT, U_VALU, U_VPERM:
        stall_pos = (cnt == CNT_W'(LAST_SLOT));
      U_COND:
        stall_pos = (cnt >= CNT_W'(CR_SLOTS));
      default:
        stall_pos = 1'b0;
    endcase
    noop_ctr = cand.ctr_branch && ctr_set;
    noop_mem = cand.load && overlap && stores_any;

    if (cand.unit == U_PSEUDO)                      hz = HZ_NONE;
    else if (stall_lead || stall_crack || stall_pos) hz = HZ_STALL;
    else if (noop_ctr || noop_mem)                  hz = HZ_NOOP;
    else                                            hz = HZ_NONE;
  end
endmodule

// File: rtl/dhz_group_tracker.sv
module dhz_group_tracker
  import dhz_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int MAX_STORES  = 4,
  parameter int CNT_W       = 3,
  parameter int ST_W        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emit,
  input  logic             advance,
  input  cand_t            cand,
  output logic [CNT_W-1:0] cnt,
  output logic             ctr_set,
  output logic [ST_W-1:0]  store_cnt,
  output logic             overrun_err
);
  localparam int WIDE      = CNT_W + 1;
  localparam int LAST_SLOT = GROUP_SLOTS - 1;
  localparam int OVERFULL  = GROUP_SLOTS + 1;

  logic [WIDE-1:0]  base, sum, adv_sum;
  logic [CNT_W-1:0] e_cnt, n_cnt;
  logic             e_ctr, n_ctr, n_err;
  logic [ST_W-1:0]  e_st, n_st;

  // emit stage
  always_comb begin
    e_cnt = cnt;
    e_ctr = ctr_set;
    e_st  = store_cnt;
    base  = ((cand.unit == U_BRANCH) || cand.single) ? WIDE'(LAST_SLOT) : WIDE'(cnt);
    sum   = base + WIDE'(1) + WIDE'(cand.cracked);
    if (emit && (cand.unit != U_PSEUDO)) begin
      if (cand.sets_ctr) e_ctr = 1'b1;
      if (cand.store && (store_cnt < ST_W'(MAX_STORES))) e_st = store_cnt + 1'b1;
      if (sum == WIDE'(GROUP_SLOTS)) begin
        e_cnt = '0;
        e_ctr = 1'b0;
        e_st  = '0;
      end else if (sum > WIDE'(GROUP_SLOTS)) begin
        e_cnt = CNT_W'(OVERFULL);
      end else begin
        e_cnt = sum[CNT_W-1:0];
      end
    end
  end

  // advance stage, applied to the emit result
  always_comb begin
    n_cnt   = e_cnt;
    n_ctr   = e_ctr;
    n_st    = e_st;
    n_err   = overrun_err;
    adv_sum = WIDE'(e_cnt) + WIDE'(1);
    if (advance) begin
      if (e_cnt >= CNT_W'(GROUP_SLOTS)) begin
        n_err = 1'b1;
        n_cnt = '0;
        n_ctr = 1'b0;
        n_st  = '0;
      end else if (adv_sum == WIDE'(GROUP_SLOTS)) begin
        n_cnt = '0;
        n_ctr = 1'b0;
        n_st  = '0;
      end else begin
        n_cnt = adv_sum[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      ctr_set     <= 1'b0;
      store_cnt   <= '0;
      overrun_err <= 1'b0;
    end else begin
      cnt         <= n_cnt;
      ctr_set     <= n_ctr;
      store_cnt   <= n_st;
      overrun_err <= n_err;
    end
  end
endmodule

// File: rtl/dispatch_hazard_top.sv
module dispatch_hazard_top
  import dhz_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int CR_SLOTS    = 2,
  parameter int MAX_STORES  = 4,
  parameter int CNT_W       = $clog2(GROUP_SLOTS + 2),
  parameter int ST_W        = $clog2(MAX_STORES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cand_unit,
  input  logic             cand_first,
  input  logic             cand_single,
  input  logic             cand_cracked,
  input  logic             cand_sets_ctr,
  input  logic             cand_ctr_branch,
  input  logic             cand_load,
  input  logic             cand_store,
  input  logic             addr_overlap,
  input  logic             emit,
  input  logic             advance,
  output logic [1:0]       hazard,
  output logic [CNT_W-1:0] slot_cnt,
  output logic             overrun_err
);
  cand_t           cand;
  hazard_e         hz;
  logic            ctr_set;
  logic [ST_W-1:0] store_cnt;

  always_comb begin
    cand.unit       = unit_e'(cand_unit);
    cand.first      = cand_first;
    cand.single     = cand_single;
    cand.cracked    = cand_cracked;
    cand.sets_ctr   = cand_sets_ctr;
    cand.ctr_branch = cand_ctr_branch;
    cand.load       = cand_load;
    cand.store      = cand_store;
  end

  dhz_rules #(
    .GROUP_SLOTS(GROUP_SLOTS),
    .CR_SLOTS   (CR_SLOTS),
    .CNT_W      (CNT_W)
  ) u_rules (
    .cand      (cand),
    .cnt       (slot_cnt),
    .ctr_set   (ctr_set),
    .stores_any(store_cnt != '0),
    .overlap   (addr_overlap),
    .hz        (hz)
  );

  dhz_group_tracker #(
    .GROUP_SLOTS(GROUP_SLOTS),
    .MAX_STORES (MAX_STORES),
    .CNT_W      (CNT_W),
    .ST_W       (ST_W)
  ) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .emit       (emit),
    .advance    (advance),
    .cand       (cand),
    .cnt        (slot_cnt),
    .ctr_set    (ctr_set),
    .store_cnt  (store_cnt),
    .overrun_err(overrun_err)
  );

  assign hazard = hz;
endmodule

// File: rtl/dispatch_hazard_chk.sv
module dispatch_hazard_chk #(
  parameter int GROUP_SLOTS = 5,
  parameter int CNT_W       = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cand_unit,
  input logic             cand_first,
  input logic             cand_single,
  input logic             emit,
  input logic             advance,
  input logic [1:0]       hazard,
  input logic [CNT_W-1:0] slot_cnt,
  input logic             overrun_err
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (slot_cnt == '0 && !overrun_err));

  assert_pseudo_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_unit == 3'd7) |-> (hazard == 2'd0));

  assert_pseudo_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !advance && cand_unit == 3'd7) |=> $stable(slot_cnt));

  assert_lead_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cand_first || cand_single) && cand_unit != 3'd7 && slot_cnt != '0) |-> (hazard == 2'd1));

  assert_cond_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_unit == 3'd5 && slot_cnt >= CNT_W'(2)) |-> (hazard == 2'd1));

  assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hazard != 2'd3);

  assert_advance_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !emit && slot_cnt < CNT_W'(GROUP_SLOTS - 1))
      |=> (slot_cnt == CNT_W'($past(slot_cnt) + 1'b1)));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_err |=> overrun_err);
endmodule

bind dispatch_hazard_top dispatch_hazard_chk #(
  .GROUP_SLOTS(GROUP_SLOTS),
  .CNT_W      (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cand_unit  (cand_unit),
  .cand_first (cand_first),
  .cand_single(cand_single),
  .emit       (emit),
  .advance    (advance),
  .hazard     (hazard),
  .slot_cnt   (slot_cnt),
  .overrun_err(overrun_err)
);

// File: tb/tb_dispatch_hazard_top.sv
`timescale 1ns/1ps
module tb_dispatch_hazard_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cand_unit = 3'd0;
  logic       cand_first = 0, cand_single = 0, cand_cracked = 0, cand_sets_ctr = 0;
  logic       cand_ctr_branch = 0, cand_load = 0, cand_store = 0, addr_overlap = 0;
  logic       emit = 0, advance = 0;
  logic [1:0] hazard;
  logic [2:0] slot_cnt;
  logic       overrun_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dispatch_hazard_top dut (
    .clk(clk), .rst_n(rst_n), .cand_unit(cand_unit), .cand_first(cand_first),
    .cand_single(cand_single), .cand_cracked(cand_cracked), .cand_sets_ctr(cand_sets_ctr),
    .cand_ctr_branch(cand_ctr_branch), .cand_load(cand_load), .cand_store(cand_store),
    .addr_overlap(addr_overlap), .emit(emit), .advance(advance),
    .hazard(hazard), .slot_cnt(slot_cnt), .overrun_err(overrun_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_cand();
    cand_unit = 3'd0; cand_first = 0; cand_single = 0; cand_cracked = 0;
    cand_sets_ctr = 0; cand_ctr_branch = 0; cand_load = 0; cand_store = 0;
    addr_overlap = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; emit = 0; advance = 0; clear_cand();
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1;
  endtask

  task automatic pulse(input bit e, input bit a);
    emit = e; advance = a;
    @(posedge clk); #1;
    emit = 0; advance = 0;
  endtask

  function automatic int exp_hz(int k, bit ctr, bit st, int unit, bit first, bit single,
                                bit cracked, bit ctrb, bit load, bit ov);
    if (unit == 7) return 0;
    if ((first || single) && k != 0) return 1;
    if (cracked && k > 2) return 1;
    if (unit <= 4 && k == 4) return 1;
    if (unit == 5 && k >= 2) return 1;
    if (ctrb && ctr) return 2;
    if (load && ov && st) return 2;
    return 0;
  endfunction

  initial begin
    #500us;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    chk(slot_cnt == 0, "R1 count", slot_cnt, 0);
    chk(overrun_err == 0, "R1 err", overrun_err, 0);
    #1 chk(hazard == 0, "R1 hazard", hazard, 0);

    // R2 R3 R4 R5 R6: hazard sweep over state and candidate
    for (int k = 0; k <= 4; k++) begin
      for (int fl = 0; fl < ((k == 0) ? 1 : 4); fl++) begin
        do_reset();
        if (k > 0) begin
          cand_unit = 3'd0; cand_sets_ctr = fl[0]; cand_store = fl[1];
          pulse(1, 0);
          clear_cand();
          for (int a = 1; a < k; a++) pulse(0, 1);
        end
        chk(slot_cnt == 3'(k), "R9 setup count", slot_cnt, k);
        for (int c = 0; c < 512; c++) begin
          cand_unit       = c[2:0];
          cand_first      = c[3];
          cand_single     = c[4];
          cand_cracked    = c[5];
          cand_ctr_branch = c[6];
          cand_load       = c[7];
          addr_overlap    = c[8];
          #1;
          begin
            int e;
            e = exp_hz(k, fl[0], fl[1], c[2:0], c[3], c[4], c[5], c[6], c[7], c[8]);
            chk(hazard == 2'(e), "R2/R3/R4/R5/R6 hazard sweep", hazard, e);
          end
        end
        clear_cand();
      end
    end

    // R7 R8 R2: emit sweep
    for (int k = 0; k <= 4; k++) begin
      for (int ui = 0; ui < 4; ui++) begin
        for (int m = 0; m < 4; m++) begin
          int unit, sum, expc;
          bit expctr;
          unit = (ui == 0) ? 0 : (ui == 1) ? 5 : (ui == 2) ? 6 : 7;
          do_reset();
          for (int a = 0; a < k; a++) pulse(0, 1);
          cand_unit = 3'(unit); cand_single = m[0]; cand_cracked = m[1];
          cand_sets_ctr = 1;
          pulse(1, 0);
          clear_cand();
          if (unit == 7) begin
            expc = k; expctr = 0;
          end else begin
            sum = ((unit == 6 || m[0]) ? 4 : k) + 1 + m[1];
            if (sum == 5) begin expc = 0; expctr = 0; end
            else if (sum > 5) begin expc = 6; expctr = 1; end
            else begin expc = sum; expctr = 1; end
          end
          chk(slot_cnt == 3'(expc), "R7 emit count", slot_cnt, expc);
          cand_unit = 3'd6; cand_ctr_branch = 1;
          #1;
          chk(hazard == (expctr ? 2'd2 : 2'd0), "R8 counter flag", hazard, expctr ? 2 : 0);
          clear_cand();
        end
      end
    end

    // R8 R7: store recorded, cleared on group close
    do_reset();
    cand_unit = 3'd1; cand_store = 1;
    pulse(1, 0);
    clear_cand();
    cand_unit = 3'd1; cand_load = 1; addr_overlap = 1;
    #1 chk(hazard == 2, "R8 store then overlapping load", hazard, 2);
    addr_overlap = 0;
    #1 chk(hazard == 0, "R6 no overlap", hazard, 0);
    clear_cand();
    for (int a = 0; a < 4; a++) pulse(0, 1);
    chk(slot_cnt == 0, "R9 close on advance", slot_cnt, 0);
    cand_unit = 3'd1; cand_load = 1; addr_overlap = 1;
    #1 chk(hazard == 0, "R7 stores cleared at close", hazard, 0);
    clear_cand();

    // R9: emit and advance together
    do_reset();
    cand_unit = 3'd0; cand_cracked = 1;
    pulse(1, 1);
    clear_cand();
    chk(slot_cnt == 3, "R9 emit then advance", slot_cnt, 3);
    pulse(0, 1);
    chk(slot_cnt == 4, "R9 advance step", slot_cnt, 4);
    pulse(0, 1);
    chk(slot_cnt == 0, "R9 close at five", slot_cnt, 0);
    chk(overrun_err == 0, "R10 no false overrun", overrun_err, 0);

    // R10: overrun
    do_reset();
    for (int a = 0; a < 4; a++) pulse(0, 1);
    cand_unit = 3'd0; cand_cracked = 1;
    pulse(1, 0);
    clear_cand();
    chk(slot_cnt == 6, "R7 overfull", slot_cnt, 6);
    pulse(0, 1);
    chk(overrun_err == 1, "R10 overrun set", overrun_err, 1);
    chk(slot_cnt == 0, "R10 group closed", slot_cnt, 0);
    pulse(0, 1);
    pulse(0, 0);
    chk(overrun_err == 1, "R10 sticky", overrun_err, 1);
    do_reset();
    chk(overrun_err == 0, "R10 cleared by reset", overrun_err, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule